// File: doc/BRIEF.md
# Descrambler Seed-Loss Watchdog

This block supervises the seed-update strobe of a receive descrambler. While the descrambler is switched on, it counts the clock cycles since the last seed update. If that gap grows past a timeout inside a 1.3 ms to 2 ms tolerance band, it raises an internal "seed lost" condition. The count is split into a power-of-two prescaler and a small tick counter, so that a long timeout at a 125 MHz clock needs only narrow counters.

The reported status bit is sticky. It goes high one cycle after the live condition appears and stays high until software reads the status register. A read only clears it when the live condition has already gone away. Disabling the descrambler restarts the timeout but leaves a latched report in place. The surrounding status register decodes a single-cycle read strobe and presents `seed_lost` as one of its read-only bits.

Top module: `seedloss_watchdog`

## Requirements
- R1: While `descr_en` is low, the timeout never expires, and the cycle count is held at its restart value.
- R2: With `descr_en` high and `seed_upd` low on T consecutive rising edges, the live condition is present after the T-th edge, and `seed_lost` is high after edge T+1 but still low after edge T. T = 2^PRESC_LOG2 × LIMIT. T must lie in [MIN_CYCLES, MAX_CYCLES], which is checked at elaboration. The defaults are 1024 × 201 = 205,824 cycles, about 1.65 ms at 125 MHz.
- R3: An edge that samples `seed_upd` high restarts the count and removes the live condition, so a fresh full period T is needed after it.
- R4: Once `seed_lost` is high, it stays high on every edge that does not sample `stat_rd` high, including edges that sample a seed update.
- R5: An edge that samples `stat_rd` high while the live condition is absent drives `seed_lost` low after that edge.
- R6: An edge that samples `stat_rd` high while the live condition is present leaves `seed_lost` high.
- R7: Dropping `descr_en` does not clear a latched `seed_lost`. After re-enabling, the full period T must elapse again before the condition re-appears.
- R8: `seed_lost` is 0 while `rst_n` is low and right after reset is released.
- R9: With PRESC_LOG2 = 0, the prescaler is omitted and the same timing holds with T = LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| descr_en | input | 1 | Descrambler enabled; the timeout runs only while this is high |
| seed_upd | input | 1 | One-cycle strobe that marks a descrambler seed update |
| stat_rd | input | 1 | One-cycle strobe that marks a read of the status register |
| seed_lost | output | 1 | Sticky seed-loss status bit |

## Verification
The live condition is registered in the tick counter, and the status bit adds one more register. As a result, `seed_lost` follows the T-th idle edge one edge later, and it falls on the edge that samples a qualifying read. The bench drives inputs and samples `seed_lost` on falling edges, and it counts rising edges from the last edge that sampled a seed update or a disabled descrambler. At each cycle of a sweep, the expected level is `k >= T+1`, computed from the configured prescale and limit. Two configurations, one prescaled (T = 20) and one direct (T = 7), are each swept one cycle past their thresholds.

// File: rtl/seedloss_pkg.sv
package seedloss_pkg;

   // Tolerance band expressed in cycles of a 125 MHz clock (1.3 ms .. 2.0 ms).
   localparam int unsigned BAND_MIN_CYC = 162_500;
   localparam int unsigned BAND_MAX_CYC = 250_000;

   // Largest prescaler width accepted by the library block.
   localparam int unsigned PRESC_LOG2_MAX = 24;

   // Total timeout length in clock cycles for a prescale/limit pair.
   function automatic int unsigned timeout_cycles(input int unsigned presc_log2,
                                                  input int unsigned limit);
      return (32'd1 << presc_log2) * limit;
   endfunction

endpackage

// File: rtl/seedloss_prescaler.sv
module seedloss_prescaler #(
   parameter int unsigned LOG2 = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (LOG2 == 0) begin : g_direct
         // Every running cycle is a tick; no storage needed.
         logic unused_direct;
         assign unused_direct = clk ^ rst_n;
         assign tick          = run;
      end else begin : g_divided
         logic [LOG2-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (!run) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick = run & (&phase_q);
      end
   endgenerate

endmodule

// File: rtl/seedloss_timer.sv
module seedloss_timer #(
   parameter int unsigned LIMIT = 201
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic expired
);

   localparam int unsigned CW      = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

   logic [CW-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (!run) begin
         count_q <= '0;
      end else if (tick && (count_q != LIMIT_C)) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign expired = (count_q == LIMIT_C);

endmodule

// File: rtl/seedloss_sticky.sv
module seedloss_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic live,
   input  logic rd,
   output logic flag
);

   logic flag_q;

   // Set wins over clear: a read only drops the bit once the cause is gone.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= live | (flag_q & ~rd);
      end
   end

   assign flag = flag_q;

endmodule

// File: rtl/seedloss_watchdog.sv
module seedloss_watchdog
   import seedloss_pkg::*;
#(
   parameter int unsigned PRESC_LOG2 = 10,
   parameter int unsigned LIMIT      = 201,
   parameter int unsigned MIN_CYCLES = BAND_MIN_CYC,
   parameter int unsigned MAX_CYCLES = BAND_MAX_CYC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic descr_en,
   input  logic seed_upd,
   input  logic stat_rd,
   output logic seed_lost
);

   localparam int unsigned TIMEOUT = timeout_cycles(PRESC_LOG2, LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("seedloss_watchdog: LIMIT must be at least 1");
      end
      if (PRESC_LOG2 > PRESC_LOG2_MAX) begin : g_bad_presc
         $error("seedloss_watchdog: PRESC_LOG2 too large");
      end
      if ((TIMEOUT < MIN_CYCLES) || (TIMEOUT > MAX_CYCLES)) begin : g_bad_band
         $error("seedloss_watchdog: timeout outside tolerance band");
      end
   endgenerate

   logic count_run;
   logic presc_tick;
   logic timeout_live;

   // Counting continues only while enabled and no seed update is sampled.
   assign count_run = descr_en & ~seed_upd;

   seedloss_prescaler #(
      .LOG2 (PRESC_LOG2)
   ) u_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (count_run),
      .tick  (presc_tick)
   );

   seedloss_timer #(
      .LIMIT (LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (count_run),
      .tick    (presc_tick),
      .expired (timeout_live)
   );

   seedloss_sticky u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .live  (timeout_live),
      .rd    (stat_rd),
      .flag  (seed_lost)
   );

endmodule

// File: rtl/seedloss_watchdog_chk.sv
module seedloss_watchdog_chk
   import seedloss_pkg::*;
#(
   parameter int unsigned PRESC_LOG2 = 10,
   parameter int unsigned LIMIT      = 201
) (
   input logic clk,
   input logic rst_n,
   input logic descr_en,
   input logic seed_upd,
   input logic stat_rd,
   input logic live,
   input logic seed_lost
);

   localparam int unsigned T  = timeout_cycles(PRESC_LOG2, LIMIT);
   localparam int unsigned IW = $clog2(T + 1);
   localparam logic [IW-1:0] T_C = IW'(T);

   // Flat idle-cycle count, independent of the prescaler/tick split.
   logic [IW-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= '0;
      end else if (!(descr_en && !seed_upd)) begin
         idle_q <= '0;
      end else if (idle_q != T_C) begin
         idle_q <= idle_q + 1'b1;
      end
   end

   assert_timeout_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live == (idle_q == T_C));

   assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !descr_en |=> !live);

   assert_update_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      seed_upd |=> !live);

   assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_lost && !stat_rd) |=> seed_lost);

   assert_flag_sets_only_from_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_lost && !live) |=> !seed_lost);

   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !live) |=> !seed_lost);

   assert_live_blocks_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      live |=> seed_lost);

   assert_disable_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!descr_en && seed_lost && !stat_rd) |=> seed_lost);

endmodule

bind seedloss_watchdog seedloss_watchdog_chk #(
   .PRESC_LOG2 (PRESC_LOG2),
   .LIMIT      (LIMIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .descr_en  (descr_en),
   .seed_upd  (seed_upd),
   .stat_rd   (stat_rd),
   .live      (timeout_live),
   .seed_lost (seed_lost)
);

// File: tb/seedloss_watchdog_bench.sv
module seedloss_watchdog_bench;

   // Configuration 0: prescaled, 4 x 5 = 20 cycles. Configuration 1: direct, 7 cycles.
   localparam int unsigned P0_LOG2 = 2;
   localparam int unsigned P0_LIM  = 5;
   localparam int unsigned P1_LOG2 = 0;
   localparam int unsigned P1_LIM  = 7;
   localparam int T0 = (1 << P0_LOG2) * P0_LIM;
   localparam int T1 = (1 << P1_LOG2) * P1_LIM;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] en   = '0;
   logic [1:0] upd  = '0;
   logic [1:0] rd   = '0;
   logic [1:0] lost;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   seedloss_watchdog #(
      .PRESC_LOG2 (P0_LOG2), .LIMIT (P0_LIM), .MIN_CYCLES (1), .MAX_CYCLES (1000)
   ) u_seedloss_watchdog (
      .clk (clk), .rst_n (rst_n), .descr_en (en[0]), .seed_upd (upd[0]),
      .stat_rd (rd[0]), .seed_lost (lost[0])
   );

   seedloss_watchdog #(
      .PRESC_LOG2 (P1_LOG2), .LIMIT (P1_LIM), .MIN_CYCLES (1), .MAX_CYCLES (1000)
   ) u_seedloss_watchdog_direct (
      .clk (clk), .rst_n (rst_n), .descr_en (en[1]), .seed_upd (upd[1]),
      .stat_rd (rd[1]), .seed_lost (lost[1])
   );

   function automatic int tmo(input int d);
      return (d == 0) ? T0 : T1;
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_flag(input int d, input logic exp, input string req);
      checks++;
      if (lost[d] !== exp) begin
         errors++;
         $display("FAIL %s dut%0d: seed_lost=%0b expected=%0b", req, d, lost[d], exp);
      end
   endtask

   // Leaves: enabled, counters restarted on the last edge, flag cleared.
   task automatic clean(input int d);
      en[d] = 1'b1; upd[d] = 1'b1; rd[d] = 1'b0;
      step();
      rd[d] = 1'b1;
      step();
      rd[d] = 1'b0;
      upd[d] = 1'b0;
   endtask

   task automatic run_dut(input int d);
      int t;
      t = tmo(d);

      // R2 / R9: per-cycle sweep of the threshold.
      clean(d);
      expect_flag(d, 1'b0, "R5");
      for (int k = 1; k <= t + 3; k++) begin
         step();
         expect_flag(d, (k >= t + 1) ? 1'b1 : 1'b0, (d == 1) ? "R9" : "R2");
      end

      // R4: seed update does not clear the latched flag.
      upd[d] = 1'b1;
      step();
      upd[d] = 1'b0;
      expect_flag(d, 1'b1, "R4");
      step();
      expect_flag(d, 1'b1, "R4");

      // R6: read while live is present keeps the flag.
      for (int k = 2; k <= t + 1; k++) step();
      rd[d] = 1'b1;
      step();
      rd[d] = 1'b0;
      expect_flag(d, 1'b1, "R6");

      // R5: read after the condition is removed clears it.
      upd[d] = 1'b1;
      step();
      upd[d] = 1'b0;
      rd[d] = 1'b1;
      step();
      rd[d] = 1'b0;
      expect_flag(d, 1'b0, "R5");

      // R3: an update just before expiry restarts the full period.
      clean(d);
      for (int k = 1; k <= t - 1; k++) begin
         step();
         expect_flag(d, 1'b0, "R3");
      end
      upd[d] = 1'b1;
      step();
      upd[d] = 1'b0;
      for (int k = 1; k <= t; k++) begin
         step();
         expect_flag(d, 1'b0, "R3");
      end
      step();
      expect_flag(d, 1'b1, "R3");

      // R7: disabling keeps the flag; re-enable needs a full period.
      en[d] = 1'b0;
      for (int k = 1; k <= 2 * t; k++) step();
      expect_flag(d, 1'b1, "R7");
      en[d] = 1'b1;
      rd[d] = 1'b1;
      step();
      rd[d] = 1'b0;
      expect_flag(d, 1'b0, "R7");
      for (int k = 2; k <= t + 1; k++) begin
         step();
         expect_flag(d, (k >= t + 1) ? 1'b1 : 1'b0, "R7");
      end

      // R1: no timeout while disabled.
      clean(d);
      en[d] = 1'b0;
      for (int k = 1; k <= 3 * t; k++) begin
         step();
         expect_flag(d, 1'b0, "R1");
      end
      en[d] = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      expect_flag(0, 1'b0, "R8");
      expect_flag(1, 1'b0, "R8");
      rst_n = 1'b1;
      step();
      expect_flag(0, 1'b0, "R8");
      expect_flag(1, 1'b0, "R8");

      run_dut(0);
      run_dut(1);

      // R8: reset mid-run clears a latched flag.
      en = 2'b11;
      for (int k = 1; k <= T0 + 2; k++) step();
      expect_flag(0, 1'b1, "R8");
      rst_n = 1'b0;
      step();
      expect_flag(0, 1'b0, "R8");
      expect_flag(1, 1'b0, "R8");
      en = 2'b00;
      rst_n = 1'b1;
      step();
      expect_flag(0, 1'b0, "R8");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule